// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block is the write half of a serial NOR flash model. A serial front-end, not part of this block, turns the bit stream into three kinds of strobe: the opcode byte, the latched address, and each data byte that follows the address (or, for a status write, each byte that follows the opcode). The controller keeps the write-enable latch, the status and configuration registers, the deep power-down flag and one busy countdown. It also holds a page staging buffer and the flash array itself. Every write-type command is checked against the status register when its opcode arrives, and takes effect only when chip select goes high.

Page programming stages bytes in a buffer that is preset to all-ones. At commit the buffer is merged into the array with a bitwise AND, so programming can only clear bits. Erase sets bytes back to 0xFF. The array update walks one byte per clock inside the busy window. Software sees the write-in-progress bit stay high until the countdown for that operation runs out. A plain byte read port lets the surrounding model, or a bench, observe the array.

Top module: `flash_write_ctrl`

## Requirements
- R1: After reset the status register reads 0x1C, the configuration register reads 0x01, power-down is low and every array byte reads 0xFF.
- R2: Page program (opcodes 0x02 and 0x32), sector erase (0xD8), bulk erase (0xC7) and status write (0x01) are accepted only when status bit 1 (write enable) is 1, status bit 0 (write in progress) is 0 and power-down is low. A refused command changes neither the array nor the registers, and the controller ignores the rest of that select period.
- R3: Opcode 0x06 sets status bit 1 and opcode 0x04 clears it.
- R4: On the clock edge that sees chip select high after an accepted program, erase or status write, status bit 1 is cleared and status bit 0 is set.
- R5: Status bit 0 then stays set for exactly the configured number of clocks for that operation (page program, sector erase, bulk erase or status write). When the countdown expires, status bits 0 and 1 are both cleared.
- R6: A page program commit replaces each byte of the addressed page with the old array byte ANDed with the buffer byte, so repeated programs AND their patterns together.
- R7: When the program address is latched, the 256-byte buffer is preset to 0xFF. Each data byte is written at the buffer index given by the low 8 address bits. That index then increments modulo 256, and the page bits are left unchanged.
- R8: A sector erase sets to 0xFF the whole sector that contains the latched address (sector size is 2^SECTOR_W bytes, aligned) and leaves other sectors unchanged. A bulk erase sets every array byte to 0xFF.
- R9: In a status write, the first data byte replaces status bits 7, 4, 3 and 2 (mask 0x9C), keeps bits 6, 5 and 0 (mask 0x61) and clears bit 1. A second data byte replaces only configuration bit 1. Further bytes are ignored.
- R10: Opcode 0x30 clears status bits 6 and 5 when chip select rises and leaves all other status bits unchanged.
- R11: Opcode 0xB9 raises power-down only while status bit 0 is 0. Opcode 0xAB drops power-down and starts a release countdown of RES_TICKS clocks, which does not set bit 0. When that countdown expires, status bits 0 and 1 are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 1 | Chip select, active low; high commits pending operations |
| opValid | input | 1 | Opcode strobe, one cycle |
| opCode | input | 8 | Opcode byte |
| addrValid | input | 1 | Address strobe, one cycle |
| addrIn | input | ADDR_W | Latched byte address |
| byteValid | input | 1 | Data byte strobe, one cycle |
| byteIn | input | 8 | Data byte |
| rdAddr | input | ADDR_W | Array observation address |
| rdData | output | 8 | Array byte at rdAddr |
| statusOut | output | 8 | Status register (bit 0 busy, bit 1 write enable) |
| configOut | output | 8 | Configuration register |
| powerDown | output | 1 | Deep power-down flag |

## Verification
The bench aims at the wrapping page index. A design that carried the increment into the page bits would write the tail of a burst into the next page. It also repeats programs on the same page: a design that wrote the buffer instead of ANDing it would restore cleared bits. It counts busy clocks exactly for each operation, so an off-by-one countdown, or a countdown that stops before the array walk is done, shows up as a wrong count. It issues write commands without write enable, while busy and while powered down. A design with a missing gate would change the array or raise busy.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

  localparam logic [7:0] OP_STAT_WR  = 8'h01;
  localparam logic [7:0] OP_PROG     = 8'h02;
  localparam logic [7:0] OP_PROG_X4  = 8'h32;
  localparam logic [7:0] OP_WEL_CLR  = 8'h04;
  localparam logic [7:0] OP_WEL_SET  = 8'h06;
  localparam logic [7:0] OP_ERR_CLR  = 8'h30;
  localparam logic [7:0] OP_SECT_ERA = 8'hD8;
  localparam logic [7:0] OP_CHIP_ERA = 8'hC7;
  localparam logic [7:0] OP_SLEEP    = 8'hB9;
  localparam logic [7:0] OP_WAKE     = 8'hAB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_SECT, ST_BULK, ST_STATWR, ST_ERRCLR, ST_DROP
  } ctrl_state_e;

  typedef struct packed {
    logic latchAddr;
    logic fillBuf;
    logic writeBuf;
    logic startProg;
    logic startSector;
    logic startBulk;
  } ctrl_strobe_t;

endpackage

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl
  import flash_wr_pkg::*;
#(
  parameter int PP_TICKS    = 300,
  parameter int SE_TICKS    = 600,
  parameter int BE_TICKS    = 2100,
  parameter int STATWR_TICKS = 24,
  parameter int RES_TICKS   = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         opValid,
  input  logic [7:0]   opCode,
  input  logic         addrValid,
  input  logic         byteValid,
  input  logic [7:0]   byteIn,
  output ctrl_strobe_t strb,
  output logic [7:0]   statusOut,
  output logic [7:0]   configOut,
  output logic         powerDown
);

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_TICKS = maxOf(maxOf(maxOf(PP_TICKS, SE_TICKS), maxOf(BE_TICKS, STATWR_TICKS)), RES_TICKS);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  ctrl_state_e state;
  logic [CNT_W-1:0] busyCnt;
  logic [7:0] statReg;
  logic [7:0] cfgReg;
  logic sleepFlag;
  logic addrSeen;
  logic [1:0] statByteIdx;
  logic canWrite;

  assign canWrite  = statReg[1] & ~statReg[0] & ~sleepFlag;
  assign statusOut = statReg;
  assign configOut = cfgReg;
  assign powerDown = sleepFlag;

  always_comb begin
    strb = '0;
    if (!csN) begin
      if (addrValid && (state == ST_PROG || state == ST_SECT)) begin
        strb.latchAddr = 1'b1;
        strb.fillBuf   = (state == ST_PROG);
      end
      if (byteValid && state == ST_PROG && addrSeen) strb.writeBuf = 1'b1;
    end else begin
      strb.startProg   = (state == ST_PROG) && addrSeen;
      strb.startSector = (state == ST_SECT) && addrSeen;
      strb.startBulk   = (state == ST_BULK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      busyCnt     <= '0;
      statReg     <= 8'h1C;
      cfgReg      <= 8'h01;
      sleepFlag   <= 1'b0;
      addrSeen    <= 1'b0;
      statByteIdx <= '0;
    end else begin
      if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
        if (busyCnt == CNT_W'(1)) statReg[1:0] <= 2'b00;
      end
      if (csN) begin
        unique case (state)
          ST_PROG, ST_SECT, ST_BULK, ST_STATWR: begin
            if (addrSeen || state == ST_BULK || state == ST_STATWR) begin
              statReg[1] <= 1'b0;
              statReg[0] <= 1'b1;
              unique case (state)
                ST_PROG:   busyCnt <= CNT_W'(PP_TICKS);
                ST_SECT:   busyCnt <= CNT_W'(SE_TICKS);
                ST_BULK:   busyCnt <= CNT_W'(BE_TICKS);
                default:   busyCnt <= CNT_W'(STATWR_TICKS);
              endcase
            end
          end
          ST_ERRCLR: statReg[6:5] <= 2'b00;
          default: ;
        endcase
        state       <= ST_IDLE;
        addrSeen    <= 1'b0;
        statByteIdx <= '0;
      end else begin
        if (opValid) begin
          unique case (opCode)
            OP_WEL_SET: statReg[1] <= 1'b1;
            OP_WEL_CLR: statReg[1] <= 1'b0;
            OP_PROG, OP_PROG_X4: state <= canWrite ? ST_PROG : ST_DROP;
            OP_SECT_ERA: state <= canWrite ? ST_SECT : ST_DROP;
            OP_CHIP_ERA: state <= canWrite ? ST_BULK : ST_DROP;
            OP_STAT_WR:  state <= canWrite ? ST_STATWR : ST_DROP;
            OP_ERR_CLR:  state <= ST_ERRCLR;
            OP_SLEEP: begin
              if (!statReg[0]) sleepFlag <= 1'b1;
              else             state <= ST_DROP;
            end
            OP_WAKE: begin
              if (sleepFlag) begin
                sleepFlag <= 1'b0;
                busyCnt   <= CNT_W'(RES_TICKS);
              end
            end
            default: state <= ST_DROP;
          endcase
        end
        if (addrValid && (state == ST_PROG || state == ST_SECT)) addrSeen <= 1'b1;
        if (byteValid && state == ST_STATWR) begin
          if (statByteIdx == 2'd0)
            statReg <= (statReg & 8'h61) | (byteIn & 8'h9C);
          else if (statByteIdx == 2'd1)
            cfgReg[1] <= byteIn[1];
          if (statByteIdx != 2'd2) statByteIdx <= statByteIdx + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/flash_wr_datapath.sv
module flash_wr_datapath
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 8,
  parameter int SECTOR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        byteIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              walkBusy
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [ADDR_W-1:0] curAddr;
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [7:0] arr [DEPTH];
  logic [ADDR_W-1:0] walkAddr;
  logic [ADDR_W-1:0] walkEnd;
  logic walkProg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (strb.latchAddr) begin
      curAddr <= addrIn;
    end else if (strb.writeBuf) begin
      curAddr[PAGE_W-1:0] <= curAddr[PAGE_W-1:0] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillBuf) begin
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'hFF;
    end else if (strb.writeBuf) begin
      pageBuf[curAddr[PAGE_W-1:0]] <= byteIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkBusy <= 1'b0;
      walkProg <= 1'b0;
      walkAddr <= '0;
      walkEnd  <= '0;
    end else if (strb.startProg) begin
      walkBusy <= 1'b1;
      walkProg <= 1'b1;
      walkAddr <= {curAddr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
      walkEnd  <= {curAddr[ADDR_W-1:PAGE_W], {PAGE_W{1'b1}}};
    end else if (strb.startSector) begin
      walkBusy <= 1'b1;
      walkProg <= 1'b0;
      walkAddr <= {curAddr[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b0}}};
      walkEnd  <= {curAddr[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b1}}};
    end else if (strb.startBulk) begin
      walkBusy <= 1'b1;
      walkProg <= 1'b0;
      walkAddr <= '0;
      walkEnd  <= '1;
    end else if (walkBusy) begin
      if (walkAddr == walkEnd) walkBusy <= 1'b0;
      else                     walkAddr <= walkAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= 8'hFF;
    end else if (walkBusy) begin
      arr[walkAddr] <= walkProg ? (arr[walkAddr] & pageBuf[walkAddr[PAGE_W-1:0]]) : 8'hFF;
    end
  end

  assign rdData = arr[rdAddr];

endmodule

// File: rtl/flash_write_ctrl.sv
module flash_write_ctrl
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 8,
  parameter int SECTOR_W     = 9,
  parameter int PP_TICKS     = 300,
  parameter int SE_TICKS     = 600,
  parameter int BE_TICKS     = 2100,
  parameter int STATWR_TICKS = 24,
  parameter int RES_TICKS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              opValid,
  input  logic [7:0]        opCode,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [7:0]        statusOut,
  output logic [7:0]        configOut,
  output logic              powerDown
);

  ctrl_strobe_t strb;
  logic walkBusy;

  flash_wr_ctrl #(
    .PP_TICKS(PP_TICKS), .SE_TICKS(SE_TICKS), .BE_TICKS(BE_TICKS),
    .STATWR_TICKS(STATWR_TICKS), .RES_TICKS(RES_TICKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .opValid(opValid), .opCode(opCode),
    .addrValid(addrValid), .byteValid(byteValid), .byteIn(byteIn),
    .strb(strb), .statusOut(statusOut), .configOut(configOut), .powerDown(powerDown)
  );

  flash_wr_datapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn), .byteIn(byteIn),
    .rdAddr(rdAddr), .rdData(rdData), .walkBusy(walkBusy)
  );

endmodule

// File: rtl/flash_wr_checker.sv
module flash_wr_checker
  import flash_wr_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input ctrl_strobe_t strb,
  input logic [7:0]   statusOut,
  input logic         powerDown,
  input logic         walkBusy
);

  logic anyCommit;
  assign anyCommit = strb.startProg | strb.startSector | strb.startBulk;

  // R2: an array commit only ever starts while not busy
  a_r2_commit_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    anyCommit |-> !statusOut[0]);

  // R4: a commit leaves busy set and write enable cleared
  a_r4_commit_flags: assert property (@(posedge clk) disable iff (!rstN)
    anyCommit |=> (statusOut[0] && !statusOut[1]));

  // R5: the array walk always finishes inside the busy window
  a_r5_walk_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    walkBusy |-> statusOut[0]);

  // R11: no commit starts while powered down
  a_r11_sleep_blocks: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> !anyCommit);

  // R6: commit strobes are mutually exclusive
  a_r6_one_commit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.startProg, strb.startSector, strb.startBulk}));

endmodule

bind flash_write_ctrl flash_wr_checker uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .statusOut(statusOut),
  .powerDown(powerDown), .walkBusy(walkBusy)
);

// File: tb/flash_write_ctrl_test.sv
`timescale 1ns/1ps
module flash_write_ctrl_test;

  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int PPT = 300, SET = 600, BET = 2100, SWT = 24, RST = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic opValid = 1'b0;
  logic [7:0] opCode = 8'h00;
  logic addrValid = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [7:0] statusOut;
  logic [7:0] configOut;
  logic powerDown;

  flash_write_ctrl uut (
    .clk(clk), .rstN(rstN), .csN(csN), .opValid(opValid), .opCode(opCode),
    .addrValid(addrValid), .addrIn(addrIn), .byteValid(byteValid), .byteIn(byteIn),
    .rdAddr(rdAddr), .rdData(rdData), .statusOut(statusOut), .configOut(configOut),
    .powerDown(powerDown)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] dataQ [32];
  logic [7:0] firstStat;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csLow();
    @(negedge clk); csN = 1'b0;
  endtask

  task automatic sendOp(input logic [7:0] op);
    @(negedge clk); opValid = 1'b1; opCode = op;
    @(negedge clk); opValid = 1'b0;
  endtask

  task automatic sendAddr(input int a);
    @(negedge clk); addrValid = 1'b1; addrIn = AW'(a);
    @(negedge clk); addrValid = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteIn = b;
    @(negedge clk); byteValid = 1'b0;
  endtask

  // raises select, then counts negedge samples with busy set
  task automatic csHighMeasure(output int cnt);
    @(negedge clk); csN = 1'b1;
    cnt = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (k == 0) firstStat = statusOut;
      if (statusOut[0]) cnt++;
      else break;
    end
  endtask

  task automatic simpleCmd(input logic [7:0] op);
    int c;
    csLow(); sendOp(op); csHighMeasure(c);
  endtask

  task automatic doProg(input logic [7:0] op, input int a, input int len, input bit waitDone, output int cnt);
    csLow(); sendOp(op); sendAddr(a);
    for (int k = 0; k < len; k++) sendByte(dataQ[k]);
    if (waitDone) csHighMeasure(cnt);
    else begin
      @(negedge clk); csN = 1'b1; @(negedge clk);
      firstStat = statusOut; cnt = -1;
    end
  endtask

  task automatic modelProg(input int a, input int len);
    logic [7:0] buf8 [256];
    int base;
    base = a & ~255;
    for (int j = 0; j < 256; j++) buf8[j] = 8'hFF;
    for (int k = 0; k < len; k++) buf8[(a + k) & 255] = dataQ[k];
    for (int j = 0; j < 256; j++) mdl[base + j] = mdl[base + j] & buf8[j];
  endtask

  task automatic readByte(input int a, output logic [7:0] d);
    rdAddr = AW'(a); #1; d = rdData;
  endtask

  task automatic compareRange(input int lo, input int hi, input string req);
    int mism; int firstA; logic [7:0] d; logic [7:0] firstD;
    mism = 0; firstA = 0; firstD = 0;
    for (int a = lo; a < hi; a++) begin
      readByte(a, d);
      if (d !== mdl[a]) begin
        if (mism == 0) begin firstA = a; firstD = d; end
        mism++;
      end
    end
    check(mism == 0, req, int'(firstD), int'(mdl[firstA]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [7:0] d;
    void'($urandom(32'd20250611));
    for (int a = 0; a < DEPTH; a++) mdl[a] = 8'hFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(statusOut == 8'h1C, "R1 status", statusOut, 8'h1C);
    check(configOut == 8'h01, "R1 config", configOut, 8'h01);
    check(powerDown == 1'b0, "R1 powerDown", powerDown, 0);
    compareRange(0, DEPTH, "R1 array erased");

    // R2 program without write enable
    dataQ[0] = 8'hAA;
    doProg(8'h02, 16, 1, 1'b1, cnt);
    check(cnt == 0, "R2 no busy without WEL", cnt, 0);
    compareRange(0, 256, "R2 array untouched");

    // R3 write enable / disable
    simpleCmd(8'h06);
    check(statusOut == 8'h1E, "R3 wel set", statusOut, 8'h1E);
    simpleCmd(8'h04);
    check(statusOut == 8'h1C, "R3 wel clear", statusOut, 8'h1C);

    // R4 R5 R6 first program
    simpleCmd(8'h06);
    dataQ[0] = 8'hF0; dataQ[1] = 8'h0F; dataQ[2] = 8'h55; dataQ[3] = 8'hAA;
    doProg(8'h02, 256 + 16, 4, 1'b1, cnt);
    modelProg(256 + 16, 4);
    check(firstStat == 8'h1D, "R4 commit flags", firstStat, 8'h1D);
    check(cnt == PPT, "R5 program busy ticks", cnt, PPT);
    check(statusOut == 8'h1C, "R5 bits cleared at expiry", statusOut, 8'h1C);
    compareRange(256, 512, "R6 first program");

    // R6 second program ANDs
    simpleCmd(8'h06);
    dataQ[0] = 8'h3C; dataQ[1] = 8'hFF; dataQ[2] = 8'hF0; dataQ[3] = 8'h0F;
    doProg(8'h32, 256 + 16, 4, 1'b1, cnt);
    modelProg(256 + 16, 4);
    readByte(256 + 16, d);
    check(d == 8'h30, "R6 and of patterns", d, 8'h30);
    compareRange(256, 512, "R6 second program");

    // R7 wrap inside page
    simpleCmd(8'h06);
    dataQ[0] = 8'h11; dataQ[1] = 8'h22; dataQ[2] = 8'h33; dataQ[3] = 8'h44;
    doProg(8'h02, 512 + 254, 4, 1'b1, cnt);
    modelProg(512 + 254, 4);
    readByte(512, d);
    check(d == 8'h33, "R7 wrapped byte", d, 8'h33);
    readByte(768, d);
    check(d == 8'hFF, "R7 next page untouched", d, 8'hFF);
    compareRange(512, 1024, "R7 page compare");

    // R2 commands refused while busy
    simpleCmd(8'h06);
    dataQ[0] = 8'h5A;
    doProg(8'h02, 768, 1, 1'b0, cnt);
    modelProg(768, 1);
    simpleCmd(8'h06);
    dataQ[0] = 8'h00;
    doProg(8'h02, 768 + 1, 1, 1'b1, cnt);
    for (int k = 0; k < PPT; k++) @(negedge clk);
    check(statusOut == 8'h1C, "R5 wel cleared by expiry", statusOut, 8'h1C);
    compareRange(768, 1024, "R2 refused while busy");

    // R8 sector erase
    simpleCmd(8'h06);
    csLow(); sendOp(8'hD8); sendAddr(16'h0123); csHighMeasure(cnt);
    for (int a = 0; a < 512; a++) mdl[a] = 8'hFF;
    check(cnt == SET, "R5 sector busy ticks", cnt, SET);
    compareRange(0, DEPTH, "R8 sector erase");

    // R9 status write
    simpleCmd(8'h06);
    csLow(); sendOp(8'h01); sendByte(8'hFF); sendByte(8'h02); sendByte(8'h00); csHighMeasure(cnt);
    check(cnt == SWT, "R5 status write ticks", cnt, SWT);
    check(statusOut == 8'h9C, "R9 status merge", statusOut, 8'h9C);
    check(configOut == 8'h03, "R9 config bit", configOut, 8'h03);
    simpleCmd(8'h06);
    csLow(); sendOp(8'h01); sendByte(8'h1C); sendByte(8'h00); csHighMeasure(cnt);
    check(statusOut == 8'h1C, "R9 status restore", statusOut, 8'h1C);
    check(configOut == 8'h01, "R9 config restore", configOut, 8'h01);

    // R10 clear status keeps other bits
    simpleCmd(8'h06);
    simpleCmd(8'h30);
    check(statusOut == 8'h1E, "R10 clear keeps bits", statusOut, 8'h1E);

    // R11 sleep refused while busy
    dataQ[0] = 8'h81;
    doProg(8'h02, 1024, 1, 1'b0, cnt);
    modelProg(1024, 1);
    simpleCmd(8'hB9);
    check(powerDown == 1'b0, "R11 sleep refused busy", powerDown, 0);
    for (int k = 0; k < PPT; k++) @(negedge clk);
    simpleCmd(8'hB9);
    check(powerDown == 1'b1, "R11 sleep entered", powerDown, 1);
    simpleCmd(8'h06);
    dataQ[0] = 8'h00;
    doProg(8'h02, 1280, 1, 1'b1, cnt);
    check(cnt == 0, "R11 program refused asleep", cnt, 0);
    compareRange(1024, 1536, "R11 array after sleep");
    simpleCmd(8'hAB);
    check(powerDown == 1'b0 && statusOut == 8'h1E, "R11 wake no busy", statusOut, 8'h1E);
    for (int k = 0; k < RST + 2; k++) @(negedge clk);
    check(statusOut == 8'h1C, "R11 release expiry", statusOut, 8'h1C);

    // R8 bulk erase
    simpleCmd(8'h06);
    csLow(); sendOp(8'hC7); csHighMeasure(cnt);
    for (int a = 0; a < DEPTH; a++) mdl[a] = 8'hFF;
    check(cnt == BET, "R5 bulk busy ticks", cnt, BET);
    compareRange(0, DEPTH, "R8 bulk erase");

    // random programs, R2 R6 R7
    for (int it = 0; it < 24; it++) begin
      int a; int len; bit wen; logic [7:0] op;
      a = int'($urandom % DEPTH);
      len = 1 + int'($urandom % 20);
      wen = ($urandom % 4) != 0;
      op = ($urandom % 2) ? 8'h02 : 8'h32;
      for (int k = 0; k < len; k++) dataQ[k] = 8'($urandom);
      if (wen) simpleCmd(8'h06);
      doProg(op, a, len, 1'b1, cnt);
      if (wen) modelProg(a, len);
      check(cnt == (wen ? PPT : 0), "R5 random busy", cnt, wen ? PPT : 0);
      compareRange(a & ~255, (a & ~255) + 256, "R7 random page");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule